// File: doc/BRIEF.md
# Warp Fetch and Issue Scheduler

This block feeds a SIMT execution stage. It holds a program counter and a lane-enable mask for each warp. Every cycle it chooses one warp to send a fetch request to instruction memory. It also chooses one warp, which may be a different warp, whose buffered instruction goes to the execution lanes. Each warp has at most one instruction in flight between fetch and issue, so instructions leave a warp in program order. Warps that are ready may overtake one another.

A per-warp scoreboard keeps one busy bit for each architectural register. A buffered instruction is held back until both of its source registers and its destination register are free. Writeback messages from the execution side clear the busy bits.

Selection has two policies:
- Round-robin rotates through the warps.
- Greedy stays on a focus warp. It moves on only when that warp's fetch misses in the instruction cache or when that warp issues a branch.

A branch parks its warp until a redirect supplies the new PC and lane mask.

Top module: `wfs_sched`

## Requirements
- R1: While reset is held and afterwards, every warp has PC `BOOT_PC` (0), a lane mask of all ones, and no buffered instruction. The first request after reset is for warp 0 at PC 0, and no issue takes place until an instruction has been returned.
- R2: A warp with no outstanding fetch and no buffered instruction is eligible to fetch. A request stays valid until `freq_ready_i` accepts it.
- R3: In round-robin mode, the fetch search and the issue search each start at the warp after the last warp that search granted. Each pointer moves only when its grant is taken.
- R4: In greedy mode, only the focus warp (warp 0 after reset) may fetch or issue. The focus becomes (focus+1) mod warps when the focus warp receives a miss response or issues a branch.
- R5: A response with `frsp_miss_i` high leaves the warp waiting. The warp is neither refetched nor issued until a non-miss response for it arrives.
- R6: Instruction fields are as follows:
  - Destination register: bits [8:6].
  - Source A: bits [5:3].
  - Source B: bits [2:0].
  - Branch flag: bit 15.

  A buffered instruction issues only when all three registers are not busy in its warp's scoreboard. A non-branch issue marks its destination busy. A writeback clears the bit. There is no bypass, so an instruction waiting on a register issues no earlier than the cycle after its writeback.
- R7: After a warp issues, it must fetch again at the issued PC+1 before it can issue again.
- R8: An issue presents the warp number, PC, lane mask and instruction word in the same cycle that `iss_valid_o` is high.
- R9: Issuing a branch parks the warp with no fetch. A redirect for a parked warp loads its PC and lane mask, and its next fetch uses the new PC. A redirect for a warp that is not parked changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| greedy_i | input | 1 | 1 = greedy policy, 0 = round-robin |
| freq_valid_o | output | 1 | Fetch request valid |
| freq_ready_i | input | 1 | Instruction memory accepts the request |
| freq_warp_o | output | WW | Warp being fetched |
| freq_pc_o | output | PC_W | PC being fetched |
| frsp_valid_i | input | 1 | Fetch response valid |
| frsp_warp_i | input | WW | Warp the response belongs to |
| frsp_miss_i | input | 1 | Instruction-cache miss; data follows later |
| frsp_instr_i | input | INSTR_W | Returned instruction word |
| iss_valid_o | output | 1 | Instruction issued this cycle |
| iss_warp_o | output | WW | Issuing warp |
| iss_pc_o | output | PC_W | PC of issued instruction |
| iss_mask_o | output | LANES | Lane-enable mask of the warp |
| iss_instr_o | output | INSTR_W | Issued instruction word |
| wb_valid_i | input | 1 | Writeback clears a busy bit |
| wb_warp_i | input | WW | Writeback warp |
| wb_reg_i | input | RW | Writeback register |
| redir_valid_i | input | 1 | Branch redirect valid |
| redir_warp_i | input | WW | Redirected warp |
| redir_pc_i | input | PC_W | New PC |
| redir_mask_i | input | LANES | New lane mask |

## Verification
Two collisions are provoked.

The first is a writeback that clears a register in the same cycle that a buffered instruction of that warp waits on it. The bench expects no issue in that cycle and expects the issue in the next cycle.

The second is a fetch response arriving in the same cycle that a different warp issues and a third warp's fetch request waits on an unready port. The bench checks that each function keeps its own warp and PC, using a cycle-by-cycle vector table with the expected values worked out from the rotation rules.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
    // Per-warp progress through fetch and issue
    typedef enum logic [1:0] {
        WS_EMPTY = 2'd0,  // needs a fetch
        WS_PEND  = 2'd1,  // fetch outstanding (or missed)
        WS_HELD  = 2'd2,  // instruction buffered, waiting on operands
        WS_PARK  = 2'd3   // branch issued, waiting for redirect
    } wstate_e;
endpackage

// File: rtl/wfs_pick.sv
// Rotating first-eligible picker: search starts at start_i and wraps.
module wfs_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] start_i,
    output logic          gnt_v_o,
    output logic [IW-1:0] gnt_idx_o
);
    always_comb begin
        gnt_v_o   = 1'b0;
        gnt_idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int pos;
            pos = int'(start_i) + k;
            if (pos >= N) pos = pos - N;
            if (req_i[pos]) begin
                gnt_v_o   = 1'b1;
                gnt_idx_o = IW'(pos);
            end
        end
    end
endmodule

// File: rtl/wfs_scoreboard.sv
// Per-warp register busy bits; answers readiness of each warp's held instruction.
module wfs_scoreboard #(
    parameter int NW = 4,
    parameter int NR = 8,
    localparam int WW = (NW > 1) ? $clog2(NW) : 1,
    localparam int RW = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_v_i,
    input  logic [WW-1:0]  set_w_i,
    input  logic [RW-1:0]  set_r_i,
    input  logic           clr_v_i,
    input  logic [WW-1:0]  clr_w_i,
    input  logic [RW-1:0]  clr_r_i,
    input  logic [NW*RW-1:0] qa_i,
    input  logic [NW*RW-1:0] qb_i,
    input  logic [NW*RW-1:0] qd_i,
    output logic [NW-1:0]  rdy_o
);
    typedef struct packed {
        logic [NW*NR-1:0] busy;
    } sb_t;

    sb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_v_i) s_d.busy[int'(clr_w_i) * NR + int'(clr_r_i)] = 1'b0;
        if (set_v_i) s_d.busy[int'(set_w_i) * NR + int'(set_r_i)] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar w = 0; w < NW; w++) begin : g_rdy
        logic [NR-1:0] row;
        assign row      = s_q.busy[w*NR +: NR];
        assign rdy_o[w] = !row[qa_i[w*RW +: RW]] && !row[qb_i[w*RW +: RW]]
                          && !row[qd_i[w*RW +: RW]];
    end
endmodule

// File: rtl/wfs_sched.sv
module wfs_sched
    import wfs_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int LANES     = 8,
    parameter int PC_W      = 12,
    parameter int INSTR_W   = 16,
    parameter int NUM_REGS  = 8,
    parameter int BOOT_PC   = 0,
    localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               greedy_i,
    output logic               freq_valid_o,
    input  logic               freq_ready_i,
    output logic [WW-1:0]      freq_warp_o,
    output logic [PC_W-1:0]    freq_pc_o,
    input  logic               frsp_valid_i,
    input  logic [WW-1:0]      frsp_warp_i,
    input  logic               frsp_miss_i,
    input  logic [INSTR_W-1:0] frsp_instr_i,
    output logic               iss_valid_o,
    output logic [WW-1:0]      iss_warp_o,
    output logic [PC_W-1:0]    iss_pc_o,
    output logic [LANES-1:0]   iss_mask_o,
    output logic [INSTR_W-1:0] iss_instr_o,
    input  logic               wb_valid_i,
    input  logic [WW-1:0]      wb_warp_i,
    input  logic [RW-1:0]      wb_reg_i,
    input  logic               redir_valid_i,
    input  logic [WW-1:0]      redir_warp_i,
    input  logic [PC_W-1:0]    redir_pc_i,
    input  logic [LANES-1:0]   redir_mask_i
);
    localparam int BR_BIT = INSTR_W - 1;

    typedef struct packed {
        logic [NUM_WARPS-1:0][PC_W-1:0]    pc;
        logic [NUM_WARPS-1:0][LANES-1:0]   mask;
        logic [NUM_WARPS-1:0][INSTR_W-1:0] ibuf;
        logic [NUM_WARPS-1:0][1:0]         st;
        logic [WW-1:0]                     rrf;   // last fetch grant
        logic [WW-1:0]                     rri;   // last issue grant
        logic [WW-1:0]                     focus; // greedy warp
    } core_t;

    core_t s_d, s_q;

    function automatic logic [WW-1:0] wnext(input logic [WW-1:0] x);
        return (int'(x) == NUM_WARPS - 1) ? '0 : x + WW'(1);
    endfunction

    // Eligibility and search start
    logic [NUM_WARPS-1:0]       elig_f, elig_i, req_f, req_i, foc_oh, rdy;
    logic [WW-1:0]              start_f, start_i;
    logic [NUM_WARPS*RW-1:0]    qa, qb, qd;
    logic                       f_v, i_v;
    logic [WW-1:0]              f_idx, i_idx;
    logic                       i_br;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        assign elig_f[w]       = (s_q.st[w] == WS_EMPTY);
        assign elig_i[w]       = (s_q.st[w] == WS_HELD) && rdy[w];
        assign foc_oh[w]       = (int'(s_q.focus) == w);
        assign qb[w*RW +: RW]  = s_q.ibuf[w][RW-1:0];
        assign qa[w*RW +: RW]  = s_q.ibuf[w][2*RW-1:RW];
        assign qd[w*RW +: RW]  = s_q.ibuf[w][3*RW-1:2*RW];
    end

    always_comb begin
        req_f   = greedy_i ? (elig_f & foc_oh) : elig_f;
        req_i   = greedy_i ? (elig_i & foc_oh) : elig_i;
        start_f = greedy_i ? s_q.focus : wnext(s_q.rrf);
        start_i = greedy_i ? s_q.focus : wnext(s_q.rri);
    end

    wfs_pick #(.N(NUM_WARPS), .IW(WW)) u_pick_f (
        .req_i(req_f), .start_i(start_f), .gnt_v_o(f_v), .gnt_idx_o(f_idx)
    );

    wfs_pick #(.N(NUM_WARPS), .IW(WW)) u_pick_i (
        .req_i(req_i), .start_i(start_i), .gnt_v_o(i_v), .gnt_idx_o(i_idx)
    );

    assign i_br = s_q.ibuf[i_idx][BR_BIT];

    wfs_scoreboard #(.NW(NUM_WARPS), .NR(NUM_REGS)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_v_i (i_v && !i_br),
        .set_w_i (i_idx),
        .set_r_i (s_q.ibuf[i_idx][3*RW-1:2*RW]),
        .clr_v_i (wb_valid_i),
        .clr_w_i (wb_warp_i),
        .clr_r_i (wb_reg_i),
        .qa_i    (qa),
        .qb_i    (qb),
        .qd_i    (qd),
        .rdy_o   (rdy)
    );

    // Ports
    assign freq_valid_o = f_v;
    assign freq_warp_o  = f_idx;
    assign freq_pc_o    = s_q.pc[f_idx];
    assign iss_valid_o  = i_v;
    assign iss_warp_o   = i_idx;
    assign iss_pc_o     = s_q.pc[i_idx];
    assign iss_mask_o   = s_q.mask[i_idx];
    assign iss_instr_o  = s_q.ibuf[i_idx];

    // Next-state
    always_comb begin
        logic hop;
        s_d = s_q;
        hop = 1'b0;

        if (f_v && freq_ready_i) begin
            s_d.st[f_idx] = WS_PEND;
            s_d.rrf       = f_idx;
        end

        if (frsp_valid_i && (s_q.st[frsp_warp_i] == WS_PEND)) begin
            if (!frsp_miss_i) begin
                s_d.st[frsp_warp_i]   = WS_HELD;
                s_d.ibuf[frsp_warp_i] = frsp_instr_i;
            end else if (greedy_i && frsp_warp_i == s_q.focus) begin
                hop = 1'b1;
            end
        end

        if (i_v) begin
            s_d.st[i_idx] = i_br ? WS_PARK : WS_EMPTY;
            s_d.pc[i_idx] = s_q.pc[i_idx] + PC_W'(1);
            s_d.rri       = i_idx;
            if (i_br && greedy_i && i_idx == s_q.focus) hop = 1'b1;
        end

        if (redir_valid_i && (s_q.st[redir_warp_i] == WS_PARK)) begin
            s_d.pc[redir_warp_i]   = redir_pc_i;
            s_d.mask[redir_warp_i] = redir_mask_i;
            s_d.st[redir_warp_i]   = WS_EMPTY;
        end

        if (hop) s_d.focus = wnext(s_q.focus);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WARPS; w++) begin
                s_q.pc[w]   <= PC_W'(BOOT_PC);
                s_q.mask[w] <= '1;
                s_q.ibuf[w] <= '0;
                s_q.st[w]   <= WS_EMPTY;
            end
            s_q.rrf   <= WW'(NUM_WARPS - 1);
            s_q.rri   <= WW'(NUM_WARPS - 1);
            s_q.focus <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wfs_sched_chk.sv
module wfs_sched_chk #(
    parameter int WW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          greedy_i,
    input logic          freq_valid_o,
    input logic          freq_ready_i,
    input logic [WW-1:0] freq_warp_o,
    input logic          iss_valid_o,
    input logic [WW-1:0] iss_warp_o,
    input logic          iss_br
);
    // R2
    freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_valid_o && !freq_ready_i) ##1 $stable(greedy_i) |-> freq_valid_o);

    // R5
    fetch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_valid_o && freq_ready_i) |=>
            !(freq_valid_o && freq_warp_o == $past(freq_warp_o)));

    // R7
    one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid_o |=> !(iss_valid_o && iss_warp_o == $past(iss_warp_o)));

    // R4
    greedy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (greedy_i && iss_valid_o) |-> !freq_valid_o);

    // R9
    park_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid_o && iss_br) |=>
            !(freq_valid_o && freq_warp_o == $past(iss_warp_o)));
endmodule

bind wfs_sched wfs_sched_chk #(.WW(WW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .greedy_i     (greedy_i),
    .freq_valid_o (freq_valid_o),
    .freq_ready_i (freq_ready_i),
    .freq_warp_o  (freq_warp_o),
    .iss_valid_o  (iss_valid_o),
    .iss_warp_o   (iss_warp_o),
    .iss_br       (iss_instr_o[INSTR_W-1])
);

// File: tb/test_wfs_sched.sv
module test_wfs_sched;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        greedy_i;
    logic        freq_valid_o, freq_ready_i;
    logic [1:0]  freq_warp_o;
    logic [11:0] freq_pc_o;
    logic        frsp_valid_i, frsp_miss_i;
    logic [1:0]  frsp_warp_i;
    logic [15:0] frsp_instr_i;
    logic        iss_valid_o;
    logic [1:0]  iss_warp_o;
    logic [11:0] iss_pc_o;
    logic [7:0]  iss_mask_o;
    logic [15:0] iss_instr_o;
    logic        wb_valid_i;
    logic [1:0]  wb_warp_i;
    logic [2:0]  wb_reg_i;
    logic        redir_valid_i;
    logic [1:0]  redir_warp_i;
    logic [11:0] redir_pc_i;
    logic [7:0]  redir_mask_i;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    wfs_sched i_wfs_sched (.*);

    typedef struct packed {
        logic rdy; logic rv; logic [1:0] rw; logic miss; logic [15:0] ins;
        logic wv; logic [1:0] ww; logic [2:0] wr;
        logic fv; logic [1:0] fw; logic [11:0] fpc;
        logic iv; logic [1:0] iw; logic [11:0] ipc;
    } vec_t;

    function automatic vec_t mk(input logic rdy, input logic rv, input logic [1:0] rw,
        input logic miss, input logic [15:0] ins, input logic wv, input logic [1:0] ww,
        input logic [2:0] wr, input logic fv, input logic [1:0] fw, input logic [11:0] fpc,
        input logic iv, input logic [1:0] iw, input logic [11:0] ipc);
        return {rdy, rv, rw, miss, ins, wv, ww, wr, fv, fw, fpc, iv, iw, ipc};
    endfunction

    // Round-robin scenario; 0x0053: dst r1, srcA r2, srcB r3; 0x0108: dst r4, srcA r1
    localparam vec_t TBL [0:10] = '{
        mk(1, 0, 0, 0, 16'h0000, 0, 0, 0, 1, 0, 0, 0, 0, 0),
        mk(1, 1, 0, 0, 16'h0053, 0, 0, 0, 1, 1, 0, 0, 0, 0),
        mk(1, 1, 1, 0, 16'h0053, 0, 0, 0, 1, 2, 0, 1, 0, 0),
        mk(0, 0, 0, 0, 16'h0000, 0, 0, 0, 1, 3, 0, 1, 1, 0),
        mk(1, 0, 0, 0, 16'h0000, 0, 0, 0, 1, 3, 0, 0, 0, 0),
        mk(1, 1, 2, 0, 16'h0053, 0, 0, 0, 1, 0, 1, 0, 0, 0),
        mk(0, 1, 0, 0, 16'h0108, 0, 0, 0, 1, 1, 1, 1, 2, 0),
        mk(0, 0, 0, 0, 16'h0000, 0, 0, 0, 1, 1, 1, 0, 0, 0),
        mk(0, 0, 0, 0, 16'h0000, 1, 0, 1, 1, 1, 1, 0, 0, 0),
        mk(0, 0, 0, 0, 16'h0000, 0, 0, 0, 1, 1, 1, 1, 0, 1),
        mk(0, 0, 0, 0, 16'h0000, 0, 0, 0, 1, 1, 1, 0, 0, 0)
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        freq_ready_i = 0; frsp_valid_i = 0; frsp_warp_i = 0; frsp_miss_i = 0;
        frsp_instr_i = 0; wb_valid_i = 0; wb_warp_i = 0; wb_reg_i = 0;
        redir_valid_i = 0; redir_warp_i = 0; redir_pc_i = 0; redir_mask_i = 0;
    endtask

    task automatic do_reset(input logic g);
        rst_n = 0; greedy_i = g; idle();
        repeat (3) @(negedge clk);
        #2 chk("R1 no issue in reset", 32'(iss_valid_o), 0);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic rsp(input logic [1:0] w, input logic miss, input logic [15:0] ins);
        frsp_valid_i = 1; frsp_warp_i = w; frsp_miss_i = miss; frsp_instr_i = ins;
    endtask

    task automatic nxt();
        @(negedge clk); idle();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // ---- vector table: round-robin (R1, R2, R3, R6, R7)
        do_reset(0);
        for (int i = 0; i < 11; i++) begin
            vec_t v;
            v = TBL[i];
            freq_ready_i = v.rdy; frsp_valid_i = v.rv; frsp_warp_i = v.rw;
            frsp_miss_i = v.miss; frsp_instr_i = v.ins;
            wb_valid_i = v.wv; wb_warp_i = v.ww; wb_reg_i = v.wr;
            #2;
            chk($sformatf("R3 row%0d fetch valid", i), 32'(freq_valid_o), 32'(v.fv));
            chk($sformatf("R3 row%0d fetch warp", i), 32'(freq_warp_o), 32'(v.fw));
            chk($sformatf("R3 row%0d fetch pc", i), 32'(freq_pc_o), 32'(v.fpc));
            chk($sformatf("R6 row%0d issue valid", i), 32'(iss_valid_o), 32'(v.iv));
            if (v.iv) begin
                chk($sformatf("R6 row%0d issue warp", i), 32'(iss_warp_o), 32'(v.iw));
                chk($sformatf("R6 row%0d issue pc", i), 32'(iss_pc_o), 32'(v.ipc));
            end
            if (i == 0) chk("R1 first fetch warp 0", 32'(freq_warp_o), 0);
            if (i == 4) chk("R2 request held until ready", 32'(freq_warp_o), 3);
            if (i == 5) chk("R7 refetch at pc+1", 32'(freq_pc_o), 1);
            if (i == 8) chk("R6 no bypass on writeback", 32'(iss_valid_o), 0);
            nxt();
        end

        // ---- miss handling (R5)
        do_reset(0);
        freq_ready_i = 1; #2 chk("R5 fetch w0", 32'(freq_warp_o), 0); nxt();
        rsp(0, 1, 16'h0000); #2 chk("R3 next warp after w0", 32'(freq_warp_o), 1); nxt();
        freq_ready_i = 1; #2; nxt();
        freq_ready_i = 1; #2; nxt();
        freq_ready_i = 1; #2; nxt();
        #2 chk("R5 missed warp not refetched", 32'(freq_valid_o), 0);
        chk("R5 missed warp not issued", 32'(iss_valid_o), 0); nxt();
        rsp(0, 0, 16'h0053); #2 chk("R5 still waiting", 32'(iss_valid_o), 0); nxt();
        #2 chk("R5 issue after fill", 32'(iss_valid_o), 1);
        chk("R5 fill warp", 32'(iss_warp_o), 0); nxt();

        // ---- greedy (R4)
        do_reset(1);
        freq_ready_i = 1; #2 chk("R4 focus w0 fetch", 32'(freq_warp_o), 0); nxt();
        rsp(0, 1, 16'h0000); #2 chk("R4 only focus fetches", 32'(freq_valid_o), 0); nxt();
        freq_ready_i = 1; #2 chk("R4 miss hops focus", 32'(freq_warp_o), 1);
        chk("R4 hop valid", 32'(freq_valid_o), 1); nxt();
        rsp(1, 0, 16'h8000); #2 chk("R4 focus busy no fetch", 32'(freq_valid_o), 0); nxt();
        #2 chk("R4 focus issues", 32'(iss_valid_o), 1);
        chk("R4 focus issue warp", 32'(iss_warp_o), 1); nxt();
        #2 chk("R4 branch hops focus", 32'(freq_warp_o), 2);
        chk("R4 branch hop valid", 32'(freq_valid_o), 1); nxt();

        // ---- branch park and redirect (R9, R8, R1 mask)
        do_reset(0);
        freq_ready_i = 1; #2; nxt();
        rsp(0, 0, 16'h8000); #2; nxt();
        #2 chk("R9 branch issues", 32'(iss_valid_o), 1);
        chk("R1 reset mask all ones", 32'(iss_mask_o), 32'hFF);
        chk("R8 issued word", 32'(iss_instr_o), 32'h8000); nxt();
        redir_valid_i = 1; redir_warp_i = 2; redir_pc_i = 12'h077; redir_mask_i = 8'h0F;
        #2 chk("R9 parked warp skipped", 32'(freq_warp_o), 1); nxt();
        redir_valid_i = 1; redir_warp_i = 0; redir_pc_i = 12'h040; redir_mask_i = 8'h0F;
        #2; nxt();
        freq_ready_i = 1; #2 chk("R3 fetch w1", 32'(freq_warp_o), 1); nxt();
        freq_ready_i = 1; #2 chk("R9 ignored redirect warp", 32'(freq_warp_o), 2);
        chk("R9 ignored redirect pc", 32'(freq_pc_o), 0); nxt();
        freq_ready_i = 1; #2; nxt();
        freq_ready_i = 1; #2 chk("R9 redirected warp", 32'(freq_warp_o), 0);
        chk("R9 redirected pc", 32'(freq_pc_o), 32'h040); nxt();
        rsp(0, 0, 16'h0000); #2; nxt();
        #2 chk("R8 issue valid", 32'(iss_valid_o), 1);
        chk("R8 issue pc", 32'(iss_pc_o), 32'h040);
        chk("R9 new mask", 32'(iss_mask_o), 32'h0F);
        chk("R8 issue word", 32'(iss_instr_o), 0); nxt();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule